// File: doc/BRIEF.md
# Segmented Triggered Capture Buffer

This block is the storage side of an on-chip logic analyzer. It watches two internal probe buses, a 12-bit data value and an 8-bit counter value, and writes them as one 20-bit word into a local memory. A word is written only on clock cycles where the sample qualifier is high. A host pulses an arm input to start a capture request. Trigger enables, match values and the window count are taken at that pulse.

With no trigger enabled, filling starts with the first qualified sample after the arm cycle and runs until the whole memory is full. With one or both trigger enables set, the memory is split into equal windows. Each window waits for its own qualified cycle on which every enabled probe equals its match value. The matching sample becomes the first word of that window. The trigger then re-arms for the next window. After the last word is stored, a done flag rises and the engine returns to idle. A synchronous read port with one cycle of latency drains the stored words.

Top module: `seg_capture`

## Requirements
- R1: A stored word holds the data probe in bits [19:8] and the counter probe in bits [7:0]. Words fill addresses 0, 1, 2, ... in the order they were sampled.
- R2: A sample is written only on a rising clock edge where `smp_en` is high. A trigger match on a cycle with `smp_en` low is not seen.
- R3: With `trig_en` = 0, capture starts with the first qualified sample after the arm cycle and continues through window boundaries until all DEPTH words are stored. The arm cycle itself is not stored.
- R4: `trig_en` bit 0 enables comparing `probe_a` with `trig_val_a`, and bit 1 enables comparing `probe_b` with `trig_val_b`. A trigger fires only when every enabled compare matches. The matching sample is stored as the first word of its window.
- R5: `win_cnt` values that are a power of two from 1 to DEPTH give that many windows of DEPTH/`win_cnt` words each. Any other value (0, non-powers, above DEPTH) is treated as 1.
- R6: In trigger mode, window k occupies addresses k*W to k*W+W-1. After a window fills, nothing is stored until a new trigger match occurs.
- R7: `done` rises together with the store of the last word. It holds until the next arm and reads 0 in the cycle after an arm.
- R8: `ready` is high while no capture is in progress. It is low from the cycle after an arm until the capture completes.
- R9: An arm during a capture aborts it. The engine restarts at address 0 with the newly presented settings.
- R10: `rd_data` presents the word at the `rd_addr` value sampled at the previous rising edge (one cycle of latency).
- R11: After reset, `ready` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample qualifier |
| probe_a | input | 12 | Data probe |
| probe_b | input | 8 | Counter probe |
| arm | input | 1 | Start (or restart) a capture request; latches settings |
| trig_en | input | 2 | Trigger compare enables: bit 0 data probe, bit 1 counter probe |
| trig_val_a | input | 12 | Match value for the data probe |
| trig_val_b | input | 8 | Match value for the counter probe |
| win_cnt | input | 11 | Requested number of windows |
| rd_addr | input | 10 | Read address |
| rd_data | output | 20 | Stored word, one cycle after the address |
| ready | output | 1 | No capture in progress |
| done | output | 1 | All windows filled since the last arm |

## Verification
The assertions check the following on every cycle:
- `done` and `ready` clear right after an arm.
- `done` only appears together with `ready`.
- `done` holds until the next arm.
- `done` can rise only on a qualified, non-arm cycle.
- Idle is re-entered only on completion.

Some behaviour can only be shown by the bench's scenarios, because it depends on memory contents:
- which samples land at which addresses;
- window splitting for every legal and clamped count;
- the need for all enabled compares to match;
- the blindness of the trigger on unqualified cycles;
- abort on re-arm.

The bench runs these scenarios against a small memory, with expected words computed from the probe pattern.

// File: rtl/seg_capture.sv
module seg_capture #(
  parameter int A_W   = 12,
  parameter int B_W   = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_en,
  input  logic [A_W-1:0] probe_a,
  input  logic [B_W-1:0] probe_b,
  input  logic           arm,
  input  logic [1:0]     trig_en,
  input  logic [A_W-1:0] trig_val_a,
  input  logic [B_W-1:0] trig_val_b,
  input  logic [AW:0]    win_cnt,
  input  logic [AW-1:0]  rd_addr,
  output logic [SW-1:0]  rd_data,
  output logic           ready,
  output logic           done
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_FILL} st_t;

  st_t            st;
  logic [SW-1:0]  mem [DEPTH];
  logic [AW-1:0]  ptr, mask_q, mask_w;
  logic [1:0]     ten_q;
  logic [A_W-1:0] va_q;
  logic [B_W-1:0] vb_q;
  int             lg;

  always_comb begin
    lg = 0;
    for (int i = 0; i <= AW; i++)
      if (win_cnt == ((AW+1)'(1) << i)) lg = i;
    mask_w = AW'((DEPTH - 1) >> lg);
  end

  wire hit     = (!ten_q[0] || probe_a == va_q) && (!ten_q[1] || probe_b == vb_q);
  wire wr      = smp_en && (st == S_FILL || (st == S_WAIT && hit));
  wire win_end = (ptr & mask_q) == mask_q;
  wire last    = ptr == AW'(DEPTH - 1);

  assign ready = st == S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      done   <= 1'b0;
      ten_q  <= '0;
      va_q   <= '0;
      vb_q   <= '0;
      mask_q <= '0;
    end else if (arm) begin
      ten_q  <= trig_en;
      va_q   <= trig_val_a;
      vb_q   <= trig_val_b;
      mask_q <= mask_w;
      ptr    <= '0;
      done   <= 1'b0;
      st     <= (trig_en != 2'b00) ? S_WAIT : S_FILL;
    end else if (wr) begin
      ptr <= ptr + 1'b1;
      if (last) begin
        st   <= S_IDLE;
        done <= 1'b1;
      end else if (win_end && ten_q != 2'b00) begin
        st <= S_WAIT;
      end else begin
        st <= S_FILL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !arm) mem[ptr] <= {probe_a, probe_b};
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/seg_capture_chk.sv
module seg_capture_chk (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic smp_en,
  input logic ready,
  input logic done
);

  // R7
  done_clears_on_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !done);

  // R8
  busy_after_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !ready);

  // R8
  done_means_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

  // R7
  done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);

  // R2
  done_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(smp_en && !arm));

  // R8
  idle_only_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> done);

endmodule

bind seg_capture seg_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .smp_en(smp_en), .ready(ready), .done(done)
);

// File: tb/sim_seg_capture.sv
`timescale 1ns/1ps
module sim_seg_capture;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, gate = 1'b0;
  logic [1:0] trig_en = '0;
  logic [11:0] trig_val_a = '0;
  logic [7:0] trig_val_b = '0;
  logic [AW:0] win_cnt = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [19:0] rd_data;
  logic ready, done;
  int c = 0;
  int checks = 0, fails = 0;
  logic [19:0] expw [DEPTH];

  always #10 clk = ~clk;
  always @(negedge clk) c <= c + 1;

  function automatic logic [11:0] fa(int v);
    return {8'(v) ^ 8'hA5, 4'(v)};
  endfunction
  function automatic logic en_of(int v, logic g);
    return g ? (v % 4 != 0) : 1'b1;
  endfunction

  wire [11:0] probe_a = fa(c);
  wire [7:0]  probe_b = 8'(c);
  wire        smp_en  = en_of(c, gate);

  seg_capture #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .probe_a(probe_a), .probe_b(probe_b),
    .arm(arm), .trig_en(trig_en), .trig_val_a(trig_val_a), .trig_val_b(trig_val_b),
    .win_cnt(win_cnt), .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready), .done(done)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nwin(int wc);
    for (int i = 0; (1 << i) <= DEPTH; i++)
      if (wc == (1 << i)) return wc;
    return 1;
  endfunction

  task automatic start(logic [1:0] te, logic [11:0] va, logic [7:0] vb, int wc, logic g,
                       output int ca);
    @(negedge clk);
    trig_en = te; trig_val_a = va; trig_val_b = vb; win_cnt = (AW+1)'(wc); gate = g;
    arm = 1'b1;
    #1 ca = c;
    @(negedge clk);
    arm = 1'b0;
    chk("R7 done low after arm", 32'(done), 0);
    chk("R8 ready low after arm", 32'(ready), 0);
  endtask

  task automatic model(int ca, logic [1:0] te, logic [11:0] va, logic [7:0] vb, int wc, logic g);
    int w = DEPTH / nwin(wc);
    int n = 0;
    int v = ca;
    logic waiting = (te != 0);
    while (n < DEPTH) begin
      v++;
      if (!en_of(v, g)) continue;
      if (waiting && !((!te[0] || fa(v) == va) && (!te[1] || 8'(v) == vb))) continue;
      expw[n] = {fa(v), 8'(v)};
      n++;
      waiting = (te != 0) && (n % w == 0);
    end
  endtask

  task automatic wait_done(string req);
    int t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk({req, " done reached"}, 32'(done), 1);
    chk("R8 ready at completion", 32'(ready), 1);
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = AW'(i);
      @(negedge clk);
      chk(req, rd_data, expw[i]);
    end
  endtask

  task automatic run(string req, logic [1:0] te, logic [11:0] va, logic [7:0] vb, int wc, logic g);
    int ca;
    start(te, va, vb, wc, g, ca);
    model(ca, te, va, vb, wc, g);
    wait_done(req);
    read_all(req);
  endtask

  initial begin
    int ca;
    int wcs [8] = '{1, 2, 4, 8, 16, 3, 0, 32};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready after reset", 32'(ready), 1);
    chk("R11 done after reset", 32'(done), 0);

    run("R3 R2 R1 immediate gated", 2'b00, '0, '0, 1, 1'b1);
    run("R3 immediate multiwindow", 2'b00, '0, '0, 4, 1'b0);

    for (int k = 0; k < 8; k++)
      run("R5 R6 R4 counter trigger gated", 2'b10, '0, 8'd9, wcs[k], 1'b1);

    run("R4 both compares", 2'b11, fa(37), 8'd37, 2, 1'b0);
    run("R4 data compare only", 2'b01, fa(200), '0, 4, 1'b0);

    // R2: match value only occurs on unqualified cycles
    start(2'b10, '0, 8'd8, 1, 1'b1, ca);
    repeat (600) @(negedge clk);
    chk("R2 no trigger on unqualified cycle", 32'(done), 0);

    // R4: both enabled, only one can match
    start(2'b11, fa(50), 8'd51, 1, 1'b0, ca);
    repeat (600) @(negedge clk);
    chk("R4 partial match ignored", 32'(done), 0);
    chk("R4 still busy", 32'(ready), 0);

    // R9: abort with a fresh immediate capture
    start(2'b00, '0, '0, 2, 1'b0, ca);
    model(ca, 2'b00, '0, '0, 2, 1'b0);
    wait_done("R9 abort restart");
    read_all("R9 abort restart");

    // R10: address change shows only after an edge
    rd_addr = AW'(3);
    @(negedge clk);
    rd_addr = AW'(5);
    #1 chk("R10 no combinational read", rd_data, expw[3]);
    @(negedge clk);
    chk("R10 one cycle latency", rd_data, expw[5]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule